// File: doc/BRIEF.md
# T1 Frame Alignment Monitor

This block sits behind a T1 frame aligner and supervises an alignment that already exists. It receives the recovered serial stream together with a bit-clock enable. From a one-bit start marker it tracks its own position inside a frame of `FRAME_BITS` bits and inside the multiframe. It compares every framing bit that carries pattern information against the value that the selected framing format expects at that frame number.

Mismatching framing bits feed one of four loss criteria and a saturating error counter. Three criteria are sliding windows over the most recent checked framing bits. The fourth counts runs of damaged multiframes. When loss is declared, the block raises a loss-of-alignment flag. With automatic mode on, it also issues a one-cycle resync request to the aligner. A force pulse or a rising external loss-of-frame input requests a resync in any mode. The flag clears only after the aligner marks a new start and one complete multiframe then checks clean.

Top module: `t1_frame_monitor`

## Requirements
- R1: After reset `lof` is 1, `resync_req` is 0 and `err_cnt` is 0.
- R2: A framing bit is taken when `bit_en` is high and either `frame_start` is high or `FRAME_BITS` enabled bits have passed since the previous framing bit. A framing bit with `frame_start` high is frame 1 of a multiframe. `fmt` sets the multiframe length: 00 gives 4 frames, 01 gives 12, 10 gives 24 and 11 gives 72.
- R3: With `fmt`=01, odd frames 1,3,…,11 expect 1,0,1,0,1,0 and even frames 2,4,…,12 expect 0,0,1,1,1,0.
- R4: With `fmt`=10, frames 4,8,12,16,20,24 expect 0,0,1,0,1,1. No other framing bit is checked, and flipping one never changes `err_cnt`.
- R5: With `fmt`=00, frames 1 and 3 expect 1 and 0. With `fmt`=11, odd frames expect an alternating 1,0 pattern starting with 1. Unchecked frames have no effect on `err_cnt`.
- R6: With `lof` low and `crit`=00, 01 or 10, `lof` is set in the cycle after the checked framing bit that makes the error total reach 2 within the last 4, 5 or 6 checked framing bits respectively.
- R7: With `lof` low and `crit`=11, `lof` is set at the end of the fourth consecutive multiframe that holds at least one errored framing bit. A clean multiframe restarts the run, and several errors inside one multiframe count as one.
- R8: While `lof` is high, it clears in the cycle after the last framing bit of the first complete multiframe that starts with `frame_start` and has no errored framing bit. An errored multiframe, or a multiframe not begun by `frame_start`, leaves `lof` high.
- R9: `err_cnt` adds 1 per errored checked framing bit and holds at 2^`CNT_W`-1. A high `cnt_clr` sets it to 0 on the next edge.
- R10: With `auto_en` high and `lof` high, `err_cnt` does not count. With `auto_en` low, it keeps counting while `lof` is high.
- R11: A loss declared under R6 or R7 pulses `resync_req` for one cycle, together with the rise of `lof`, only when `auto_en` is high.
- R12: A `force_resync` pulse or a rising edge of `ext_lof` sets `lof` and pulses `resync_req` in the next cycle, whatever `auto_en` is. While `ext_lof` stays high, `lof` cannot clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One line bit is present this cycle |
| rx_bit | input | 1 | Recovered serial data |
| frame_start | input | 1 | Aligner marker: this bit is the framing bit of frame 1 |
| fmt | input | 2 | Framing format select |
| crit | input | 2 | Loss criterion select |
| auto_en | input | 1 | Automatic resync mode |
| force_resync | input | 1 | Pulse that forces a resync |
| ext_lof | input | 1 | External loss-of-frame level |
| cnt_clr | input | 1 | Clear strobe for the error counter |
| lof | output | 1 | Loss of frame alignment |
| resync_req | output | 1 | One-cycle resync request to the aligner |
| err_cnt | output | CNT_W | Saturating framing error count |

## Verification
The bench builds the monitor with `FRAME_BITS`=3 and `CNT_W`=4. The short frames let it flip every framing position of all four formats, including every frame of the 72-frame multiframe, and observe the counter step after each flip. The 4-bit counter makes saturation reachable in two fully errored multiframes. The window criteria are swept over every spacing of two errors from 1 to 6 checks, so each window's edge is crossed from both sides.

// File: rtl/t1_frame_monitor.sv
module t1_frame_monitor #(
  parameter int FRAME_BITS = 193,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             frame_start,
  input  logic [1:0]       fmt,
  input  logic [1:0]       crit,
  input  logic             auto_en,
  input  logic             force_resync,
  input  logic             ext_lof,
  input  logic             cnt_clr,
  output logic             lof,
  output logic             resync_req,
  output logic [CNT_W-1:0] err_cnt
);

  localparam int BW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [BW-1:0]    LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [7:0]       D4_EVEN  = 8'b0001_1100;
  localparam logic [7:0]       ESF_SYNC = 8'b0011_0100;

  logic [BW-1:0] bit_cnt;
  logic [6:0]    frm, idx, last;
  logic          pos_ok, fbit, chk_on, exp_bit, chk, err, mf_end;
  logic [5:0]    hist, hist_nx, wmask;
  logic          mf_bad, mf_bad_now, win_loss, mf_loss, crit_loss;
  logic [1:0]    bad_run;
  logic          armed, ext_q, ext_rise;

  always_comb
    case (fmt)
      2'b00:   last = 7'd3;
      2'b01:   last = 7'd11;
      2'b10:   last = 7'd23;
      default: last = 7'd71;
    endcase

  assign idx  = frame_start ? 7'd0 : frm;
  assign fbit = bit_en && (frame_start || (pos_ok && bit_cnt == '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      frm     <= '0;
      pos_ok  <= 1'b0;
    end else if (bit_en) begin
      if (frame_start) begin
        bit_cnt <= BW'(1);
        frm     <= '0;
        pos_ok  <= 1'b1;
      end else if (pos_ok) begin
        if (bit_cnt == LAST_BIT) begin
          bit_cnt <= '0;
          frm     <= (frm >= last) ? 7'd0 : frm + 7'd1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end

  always_comb begin
    chk_on  = 1'b0;
    exp_bit = 1'b0;
    case (fmt)
      2'b00: begin
        chk_on  = (idx == 7'd0) || (idx == 7'd2);
        exp_bit = !idx[1];
      end
      2'b01: begin
        chk_on  = 1'b1;
        exp_bit = idx[0] ? D4_EVEN[idx[3:1]] : !idx[1];
      end
      2'b10: begin
        chk_on  = (idx[1:0] == 2'b11);
        exp_bit = ESF_SYNC[idx[4:2]];
      end
      default: begin
        chk_on  = !idx[0];
        exp_bit = !idx[1];
      end
    endcase
  end

  assign chk    = fbit && chk_on && (idx <= last);
  assign err    = chk && (rx_bit != exp_bit);
  assign mf_end = fbit && (idx == last);

  assign hist_nx = {hist[4:0], err};
  assign wmask   = (crit == 2'b00) ? 6'h0F : (crit == 2'b01) ? 6'h1F : 6'h3F;
  assign win_loss = chk && !lof && (crit != 2'b11) && ($countones(hist_nx & wmask) >= 2);

  assign mf_bad_now = (!frame_start && mf_bad) || err;
  assign mf_loss    = mf_end && !lof && (crit == 2'b11) && mf_bad_now && (bad_run == 2'd3);
  assign crit_loss  = win_loss || mf_loss;
  assign ext_rise   = ext_lof && !ext_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist       <= '0;
      mf_bad     <= 1'b0;
      bad_run    <= '0;
      lof        <= 1'b1;
      armed      <= 1'b0;
      ext_q      <= 1'b0;
      resync_req <= 1'b0;
    end else begin
      ext_q      <= ext_lof;
      resync_req <= force_resync || ext_rise || (crit_loss && auto_en);

      if (lof)      hist <= '0;
      else if (chk) hist <= hist_nx;

      if (fbit) mf_bad <= mf_end ? 1'b0 : mf_bad_now;

      if (lof)
        bad_run <= '0;
      else if (mf_end)
        bad_run <= !mf_bad_now ? 2'd0 : (bad_run == 2'd3) ? 2'd3 : bad_run + 2'd1;

      if (force_resync || ext_lof || crit_loss)
        lof <= 1'b1;
      else if (mf_end && armed && !mf_bad_now)
        lof <= 1'b0;

      if (force_resync || ext_lof)
        armed <= 1'b0;
      else if (fbit && frame_start && lof)
        armed <= 1'b1;
      else if (mf_end)
        armed <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      err_cnt <= '0;
    else if (cnt_clr)
      err_cnt <= '0;
    else if (err && !(auto_en && lof) && err_cnt != CNT_MAX)
      err_cnt <= err_cnt + 1'b1;

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == CNT_MAX && !cnt_clr) |=> (err_cnt == CNT_MAX));

  // R9
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

  // R10
  auto_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && lof && !cnt_clr) |=> $stable(err_cnt));

  // R12
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_resync |=> (lof && resync_req));

  // R12
  ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_lof && !ext_q) |=> (lof && resync_req));

  // R8
  clear_at_mf_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof) |-> $past(mf_end && !ext_lof));

  // R11
  no_auto_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !force_resync && !(ext_lof && !ext_q)) |=> !resync_req);

endmodule

// File: tb/test_t1_frame_monitor.sv
module test_t1_frame_monitor;
  localparam int FB = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, frame_start = 1'b0;
  logic [1:0] fmt = 2'b00, crit = 2'b00;
  logic auto_en = 1'b0, force_resync = 1'b0, ext_lof = 1'b0, cnt_clr = 1'b0;
  logic lof, resync_req;
  logic [CW-1:0] err_cnt;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  t1_frame_monitor #(.FRAME_BITS(FB), .CNT_W(CW)) i_t1_frame_monitor (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_start(frame_start), .fmt(fmt), .crit(crit), .auto_en(auto_en),
    .force_resync(force_resync), .ext_lof(ext_lof), .cnt_clr(cnt_clr),
    .lof(lof), .resync_req(resync_req), .err_cnt(err_cnt));

  always @(posedge clk) if (resync_req === 1'b1) pulses++;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int mf_len(input int f);
    return (f == 0) ? 4 : (f == 1) ? 12 : (f == 2) ? 24 : 72;
  endfunction

  // {checked, expected value} for 0-based frame i
  function automatic logic [1:0] model(input int f, input int i);
    logic c, e;
    c = 1'b0; e = 1'b0;
    case (f)
      0: begin c = (i == 0 || i == 2); e = (i == 0); end
      1: begin
        c = 1'b1;
        if (i % 2 == 0) e = ((i / 2) % 2 == 0);
        else            e = ((i / 2) >= 2 && (i / 2) <= 4);
      end
      2: begin c = (i % 4 == 3); e = ((i / 4) == 2 || (i / 4) == 4 || (i / 4) == 5); end
      default: begin c = (i % 2 == 0); e = ((i / 2) % 2 == 0); end
    endcase
    return {c, e};
  endfunction

  task automatic send_bit(input logic b, input logic fs);
    @(negedge clk);
    rx_bit = b; frame_start = fs; bit_en = 1'b1;
  endtask

  task automatic send_mf(input int f, input bit start, input logic [71:0] flips);
    for (int i = 0; i < mf_len(f); i++) begin
      logic [1:0] m;
      m = model(f, i);
      send_bit((m[1] & m[0]) ^ flips[i], start && (i == 0));
      for (int j = 1; j < FB; j++) send_bit(1'b0, 1'b0);
    end
    @(negedge clk);
    bit_en = 1'b0; frame_start = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic clear_cnt();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [71:0] m;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lof", lof, 1);
    check("R1 resync_req", resync_req, 0);
    check("R1 err_cnt", err_cnt, 0);

    // R2 R3 R4 R5: flip every framing position of every format
    for (int f = 0; f < 4; f++) begin
      fmt = 2'(f); crit = 2'b00;
      send_mf(f, 1, '0);
      check("R2/R8 align", lof, 0);
      for (int p = 0; p < mf_len(f); p++) begin
        logic [1:0] md;
        md = model(f, p);
        clear_cnt();
        send_mf(f, 0, 72'(1) << p);
        if (f == 1)      check("R3 pattern", err_cnt, md[1]);
        else if (f == 2) check("R4 pattern", err_cnt, md[1]);
        else             check("R5 pattern", err_cnt, md[1]);
        send_mf(f, 0, '0);
        send_mf(f, 0, '0);
        check("R6 single error keeps lock", lof, 0);
      end
    end

    // R6: window criteria, two errors g checks apart
    fmt = 2'b01;
    for (int c = 0; c < 3; c++) begin
      crit = 2'(c);
      for (int g = 1; g <= 6; g++) begin
        send_mf(1, 1, '0);
        check("R8 realign", lof, 0);
        p0 = pulses;
        send_mf(1, 0, (72'(1) << g) | 72'(1));
        check("R6 window", lof, (g <= c + 3) ? 1 : 0);
        check("R11 no request without auto", pulses, p0);
      end
    end

    // R7: consecutive bad multiframes
    fmt = 2'b10; crit = 2'b11;
    send_mf(2, 1, '0);
    m = '0;
    for (int k = 0; k < 6; k++) m[4 * k + 3] = 1'b1;
    for (int k = 0; k < 3; k++) send_mf(2, 0, m);
    check("R7 three bad", lof, 0);
    send_mf(2, 0, '0);
    for (int k = 0; k < 3; k++) send_mf(2, 0, 72'(1) << 3);
    check("R7 run restarted", lof, 0);
    send_mf(2, 0, 72'(1) << 23);
    check("R7 fourth bad", lof, 1);

    // R11 + R10: automatic mode
    fmt = 2'b01; crit = 2'b00; auto_en = 1'b1;
    send_mf(1, 1, '0);
    check("R8 realign", lof, 0);
    clear_cnt();
    p0 = pulses;
    send_mf(1, 0, 72'h3);
    check("R11 lof", lof, 1);
    check("R11 one request", pulses, p0 + 1);
    check("R9 counted before loss", err_cnt, 2);
    send_mf(1, 0, 72'hFFF);
    check("R10 frozen in auto", err_cnt, 2);

    // R8: recovery rules
    auto_en = 1'b0;
    send_mf(1, 1, 72'(1) << 5);
    check("R8 errored mf", lof, 1);
    send_mf(1, 0, '0);
    check("R8 no start", lof, 1);
    send_mf(1, 1, '0);
    check("R8 clean", lof, 0);

    // R12 force, R9 saturation, R10 non-auto counting
    @(negedge clk); force_resync = 1'b1;
    @(negedge clk); force_resync = 1'b0;
    check("R12 force lof", lof, 1);
    check("R12 force req", resync_req, 1);
    clear_cnt();
    send_mf(1, 0, 72'hFFF);
    check("R10 counts in non-auto", err_cnt, 12);
    send_mf(1, 0, 72'hFFF);
    check("R9 saturate", err_cnt, 15);
    clear_cnt();
    check("R9 clear", err_cnt, 0);

    // R12 external loss
    send_mf(1, 1, '0);
    check("R8 realign", lof, 0);
    p0 = pulses;
    @(negedge clk); ext_lof = 1'b1;
    @(negedge clk);
    check("R12 ext lof", lof, 1);
    check("R12 ext req", resync_req, 1);
    send_mf(1, 1, '0);
    check("R12 held ext blocks", lof, 1);
    check("R12 single request", pulses, p0 + 1);
    ext_lof = 1'b0;
    send_mf(1, 1, '0);
    check("R12 released", lof, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule